// File: doc/BRIEF.md
# Load-Level CPU Clock Parent and Divider Selector

This block decides which clock parent and which divider the CPU clock uses. Software fills a small table that describes four performance load levels. Each level entry holds a parent select, a divider and a clock-select flag. Software also sets a current-level register and a global dynamic-scaling enable. When scaling is enabled, the entry chosen by the current level drives the outputs. When scaling is disabled, the parent and the divider come from fixed fields of two static select registers, and the flag output is held at zero.

The block also answers divider queries. A caller presents a requested divider, and the block returns the lowest load level whose divider field equals the request. If no entry matches, or if scaling is disabled, it raises an error instead. The outputs are combinational views of the registers, so a register write shows at the outputs from the cycle after the write.

Top module: `lvl_freq_sel`

## Requirements
- R1: A synchronous reset clears every register, so the static path is active. After reset, act_parent, act_div and act_flag read 0, and req_err is 1 for any request.
- R2: Registers and their byte addresses:
  - 0x00 and 0x04 (the static select registers) and 0x18 and 0x1C (the table registers) store all 32 bits and read back as written.
  - 0x30 (current level) keeps only bits [1:0] and reads back with all other bits 0.
  - 0x24 (scaling enable) keeps only bit 31 and reads back with all other bits 0.
  - A write to any other address changes no register, and any other address reads 0.
- R3: Each level lives in one 16-bit half of a table register:
  - level 0 is bits [31:16] of 0x18;
  - level 1 is bits [15:0] of 0x18;
  - level 2 is bits [31:16] of 0x1C;
  - level 3 is bits [15:0] of 0x1C.
- R4: Within a 16-bit half, the divider is bits [15:13], the clock-select flag is bit 11 and the parent select is bits [10:9]. All other bits of the half are ignored.
- R5: When scaling is enabled, act_parent, act_div and act_flag equal the fields of the entry that the current level picks.
- R6: When scaling is disabled:
  - act_parent equals bits [23:22] of register 0x00;
  - act_div equals bits [30:28] of register 0x04;
  - act_flag is 0.
- R7: When scaling is enabled and at least one entry's divider equals req_div, req_err is 0 and req_level is the lowest index among the matching entries.
- R8: When scaling is enabled and no entry's divider equals req_div, req_err is 1 and req_level is 0.
- R9: When scaling is disabled, req_err is 1 and req_level is 0 whatever the table holds.
- R10: A register write takes effect on the clock edge that samples it, and the outputs reflect it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_div | input | 3 | Requested divider to search for |
| act_parent | output | 2 | Active clock parent select |
| act_div | output | 3 | Active divider |
| act_flag | output | 1 | Active clock-select flag |
| req_level | output | 2 | Lowest level matching req_div |
| req_err | output | 1 | No match, or scaling disabled |

## Verification
Several entries are loaded with the same divider, so a search that picks the highest or the last matching index returns the wrong level. Each of the four levels is selected in turn, so a design that swaps the halves or the registers of the table shows a wrong parent or divider. Writes with every bit set are used for the current-level and enable registers and for the static fields, so a design that decodes a neighbouring bit or keeps stray bits reads back wrong or selects the wrong source. A divider that matches an entry is also requested while scaling is off, and a design that searches anyway clears the error where it must stay raised.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_W   = 16;
    localparam int LEVELS   = 4;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int TBL_REGS = LEVELS / 2;
    localparam int DIV_W    = 3;
    localparam int PAR_W    = 2;

    // Field positions inside one 16-bit table half.
    localparam int H_DIV_LSB = 13;
    localparam int H_FLG_BIT = 11;
    localparam int H_PAR_LSB = 9;

    // Static-path and control bit positions.
    localparam int S_PAR_LSB  = 22;
    localparam int S_DIV_LSB  = 28;
    localparam int EN_BIT     = 31;

    // Register byte addresses.
    localparam int A_STAT_PAR = 'h00;
    localparam int A_STAT_DIV = 'h04;
    localparam int A_TBL_BASE = 'h18;
    localparam int A_DYN_EN   = 'h24;
    localparam int A_CUR_LVL  = 'h30;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             flag;
        logic [PAR_W-1:0] par;
    } lvl_entry_t;

    typedef struct packed {
        logic [DATA_W-1:0]                stat_par;
        logic [DATA_W-1:0]                stat_div;
        logic [TBL_REGS-1:0][DATA_W-1:0]  tbl;
        logic                             dyn_en;
        logic [LVL_W-1:0]                 cur_lvl;
    } regs_t;

    function automatic lvl_entry_t unpack_half(input logic [HALF_W-1:0] h);
        lvl_entry_t e;
        e.div  = h[H_DIV_LSB +: DIV_W];
        e.flag = h[H_FLG_BIT];
        e.par  = h[H_PAR_LSB +: PAR_W];
        return e;
    endfunction

    // Even levels sit in the upper half of their register.
    function automatic bit level_upper(input int idx);
        return (idx % 2) == 0;
    endfunction

endpackage

// File: rtl/lvl_regfile.sv
module lvl_regfile
    import lvl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output regs_t             regs,
    output logic [DATA_W-1:0] rdata
);

    logic                hit_sp, hit_sd, hit_en, hit_lv;
    logic [TBL_REGS-1:0] hit_tbl;

    assign hit_sp = (addr == ADDR_W'(A_STAT_PAR));
    assign hit_sd = (addr == ADDR_W'(A_STAT_DIV));
    assign hit_en = (addr == ADDR_W'(A_DYN_EN));
    assign hit_lv = (addr == ADDR_W'(A_CUR_LVL));

    for (genvar g = 0; g < TBL_REGS; g++) begin : g_tbl_hit
        assign hit_tbl[g] = (addr == ADDR_W'(A_TBL_BASE + 4 * g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            if (hit_sp) regs.stat_par <= wdata;
            if (hit_sd) regs.stat_div <= wdata;
            if (hit_en) regs.dyn_en   <= wdata[EN_BIT];
            if (hit_lv) regs.cur_lvl  <= wdata[LVL_W-1:0];
            for (int i = 0; i < TBL_REGS; i++) begin
                if (hit_tbl[i]) regs.tbl[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_sp) rdata = regs.stat_par;
        if (hit_sd) rdata = regs.stat_div;
        if (hit_en) rdata[EN_BIT] = regs.dyn_en;
        if (hit_lv) rdata[LVL_W-1:0] = regs.cur_lvl;
        for (int i = 0; i < TBL_REGS; i++) begin
            if (hit_tbl[i]) rdata = regs.tbl[i];
        end
    end

endmodule

// File: rtl/lvl_table_decode.sv
module lvl_table_decode
    import lvl_pkg::*;
(
    input  logic [TBL_REGS-1:0][DATA_W-1:0] tbl,
    output lvl_entry_t                      ent [LEVELS]
);

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (level_upper(g)) begin : g_up
            assign ent[g] = unpack_half(tbl[g/2][DATA_W-1:HALF_W]);
        end else begin : g_lo
            assign ent[g] = unpack_half(tbl[g/2][HALF_W-1:0]);
        end
    end

endmodule

// File: rtl/lvl_select.sv
module lvl_select
    import lvl_pkg::*;
(
    input  lvl_entry_t        ent [LEVELS],
    input  logic              dyn_en,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic [DATA_W-1:0] stat_par,
    input  logic [DATA_W-1:0] stat_div,
    output lvl_entry_t        act
);

    always_comb begin
        if (dyn_en) begin
            act = ent[cur_lvl];
        end else begin
            act.div  = stat_div[S_DIV_LSB +: DIV_W];
            act.flag = 1'b0;
            act.par  = stat_par[S_PAR_LSB +: PAR_W];
        end
    end

endmodule

// File: rtl/lvl_search.sv
module lvl_search
    import lvl_pkg::*;
(
    input  lvl_entry_t       ent [LEVELS],
    input  logic             dyn_en,
    input  logic [DIV_W-1:0] req_div,
    output logic [LVL_W-1:0] hit_lvl,
    output logic             err
);

    logic [LEVELS-1:0] match;

    for (genvar g = 0; g < LEVELS; g++) begin : g_cmp
        assign match[g] = dyn_en && (ent[g].div == req_div);
    end

    // Scan from the top down so the lowest matching index is kept last.
    always_comb begin
        hit_lvl = '0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (match[i]) hit_lvl = LVL_W'(i);
        end
        err = ~|match;
    end

endmodule

// File: rtl/lvl_freq_sel.sv
module lvl_freq_sel
    import lvl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [2:0]        req_div,
    output logic [1:0]        act_parent,
    output logic [2:0]        act_div,
    output logic              act_flag,
    output logic [1:0]        req_level,
    output logic              req_err
);

    regs_t      regs_w;
    lvl_entry_t ent_w [LEVELS];
    lvl_entry_t act_w;

    lvl_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .regs  (regs_w),
        .rdata (reg_rdata)
    );

    lvl_table_decode u_dec (
        .tbl (regs_w.tbl),
        .ent (ent_w)
    );

    lvl_select u_sel (
        .ent      (ent_w),
        .dyn_en   (regs_w.dyn_en),
        .cur_lvl  (regs_w.cur_lvl),
        .stat_par (regs_w.stat_par),
        .stat_div (regs_w.stat_div),
        .act      (act_w)
    );

    lvl_search u_srch (
        .ent     (ent_w),
        .dyn_en  (regs_w.dyn_en),
        .req_div (req_div),
        .hit_lvl (req_level),
        .err     (req_err)
    );

    assign act_parent = act_w.par;
    assign act_div    = act_w.div;
    assign act_flag   = act_w.flag;

endmodule

// File: rtl/lvl_freq_sel_chk.sv
module lvl_freq_sel_chk
    import lvl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input regs_t             regs_w,
    input lvl_entry_t        ent_w [LEVELS],
    input logic [2:0]        req_div,
    input logic [1:0]        act_parent,
    input logic [2:0]        act_div,
    input logic              act_flag,
    input logic [1:0]        req_level,
    input logic              req_err
);

    logic rst_q;
    logic known_addr;

    always_ff @(posedge clk) rst_q <= rst;

    assign known_addr = (reg_addr == ADDR_W'(A_STAT_PAR)) || (reg_addr == ADDR_W'(A_STAT_DIV))
                     || (reg_addr == ADDR_W'(A_TBL_BASE)) || (reg_addr == ADDR_W'(A_TBL_BASE + 4))
                     || (reg_addr == ADDR_W'(A_DYN_EN))   || (reg_addr == ADDR_W'(A_CUR_LVL));

    assert_reset_static_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (act_parent == 2'd0 && act_div == 3'd0 && !act_flag && req_err));

    assert_level_write_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(A_CUR_LVL)) |=> (regs_w.cur_lvl == $past(reg_wdata[1:0])));

    assert_unknown_write_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !known_addr) |=> $stable(regs_w));

    assert_active_entry_R5: assert property (@(posedge clk) disable iff (rst)
        regs_w.dyn_en |-> (act_div == ent_w[regs_w.cur_lvl].div && act_parent == ent_w[regs_w.cur_lvl].par));

    assert_static_path_R6: assert property (@(posedge clk) disable iff (rst)
        !regs_w.dyn_en |-> (act_div == regs_w.stat_div[30:28] && act_parent == regs_w.stat_par[23:22] && !act_flag));

    assert_hit_matches_R7: assert property (@(posedge clk) disable iff (rst)
        !req_err |-> (ent_w[req_level].div == req_div));

    assert_lowest_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_err && req_level != 2'd0) |-> (ent_w[0].div != req_div));

    assert_err_level_zero_R8: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (req_level == 2'd0));

    assert_err_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !regs_w.dyn_en |-> req_err);

endmodule

bind lvl_freq_sel lvl_freq_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .regs_w     (regs_w),
    .ent_w      (ent_w),
    .req_div    (req_div),
    .act_parent (act_parent),
    .act_div    (act_div),
    .act_flag   (act_flag),
    .req_level  (req_level),
    .req_err    (req_err)
);

// File: tb/lvl_freq_sel_tb.sv
module lvl_freq_sel_tb;

    localparam int ADDR_W = 8;
    localparam int NV     = 10;

    typedef struct packed {
        logic [3:0][2:0] ldiv;
        logic [3:0]      lflag;
        logic [3:0][1:0] lpar;
        logic            en;
        logic [1:0]      lvl;
        logic [2:0]      sdiv;
        logic [1:0]      spar;
        logic [2:0]      req;
        logic [1:0]      e_par;
        logic [2:0]      e_div;
        logic            e_flag;
        logic            e_err;
        logic [1:0]      e_hit;
    } vec_t;

    // Packed arrays list level 3 first.
    localparam vec_t VECS [NV] = '{
        '{{3'd6,3'd4,3'd2,3'd1}, 4'b0010, {2'd3,2'd2,2'd1,2'd0}, 1'b1, 2'd0, 3'd5, 2'd3, 3'd4, 2'd0, 3'd1, 1'b0, 1'b0, 2'd2},
        '{{3'd6,3'd4,3'd2,3'd1}, 4'b0010, {2'd3,2'd2,2'd1,2'd0}, 1'b1, 2'd1, 3'd5, 2'd3, 3'd1, 2'd1, 3'd2, 1'b1, 1'b0, 2'd0},
        '{{3'd6,3'd4,3'd2,3'd1}, 4'b0010, {2'd3,2'd2,2'd1,2'd0}, 1'b1, 2'd2, 3'd5, 2'd3, 3'd6, 2'd2, 3'd4, 1'b0, 1'b0, 2'd3},
        '{{3'd6,3'd4,3'd2,3'd1}, 4'b0010, {2'd3,2'd2,2'd1,2'd0}, 1'b1, 2'd3, 3'd5, 2'd3, 3'd3, 2'd3, 3'd6, 1'b0, 1'b1, 2'd0},
        '{{3'd5,3'd5,3'd5,3'd3}, 4'b1000, {2'd1,2'd0,2'd3,2'd2}, 1'b1, 2'd3, 3'd0, 2'd0, 3'd5, 2'd1, 3'd5, 1'b1, 1'b0, 2'd1},
        '{{3'd5,3'd5,3'd5,3'd3}, 4'b1000, {2'd1,2'd0,2'd3,2'd2}, 1'b1, 2'd3, 3'd0, 2'd0, 3'd3, 2'd1, 3'd5, 1'b1, 1'b0, 2'd0},
        '{{3'd5,3'd5,3'd5,3'd3}, 4'b1000, {2'd1,2'd0,2'd3,2'd2}, 1'b0, 2'd1, 3'd5, 2'd2, 3'd3, 2'd2, 3'd5, 1'b0, 1'b1, 2'd0},
        '{{3'd0,3'd0,3'd0,3'd0}, 4'b0000, {2'd0,2'd0,2'd0,2'd0}, 1'b1, 2'd2, 3'd7, 2'd1, 3'd0, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0},
        '{{3'd7,3'd7,3'd7,3'd7}, 4'b1111, {2'd3,2'd3,2'd3,2'd3}, 1'b1, 2'd0, 3'd1, 2'd1, 3'd7, 2'd3, 3'd7, 1'b1, 1'b0, 2'd0},
        '{{3'd7,3'd7,3'd7,3'd7}, 4'b1111, {2'd3,2'd3,2'd3,2'd3}, 1'b1, 2'd0, 3'd1, 2'd1, 3'd2, 2'd3, 3'd7, 1'b1, 1'b1, 2'd0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [2:0]        req_div = '0;
    logic [1:0]        act_parent;
    logic [2:0]        act_div;
    logic              act_flag;
    logic [1:0]        req_level;
    logic              req_err;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    lvl_freq_sel #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .req_div    (req_div),
        .act_parent (act_parent),
        .act_div    (act_div),
        .act_flag   (act_flag),
        .req_level  (req_level),
        .req_err    (req_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Half layout per R4: divider [15:13], flag 11, parent [10:9].
    function automatic logic [15:0] half(input logic [2:0] d, input logic f, input logic [1:0] p);
        logic [15:0] h;
        h = '0;
        h[15:13] = d;
        h[11]    = f;
        h[10:9]  = p;
        return h;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        req_div = 3'd0;
        #1;
        // R1: reset state, static path, error raised
        chk("R1 act_parent", 32'(act_parent), 0);
        chk("R1 act_div", 32'(act_div), 0);
        chk("R1 act_flag", 32'(act_flag), 0);
        chk("R1 req_err", 32'(req_err), 1);
        rd_chk("R1 table reg 0x18", 8'h18, 0);
        rd_chk("R1 enable reg", 8'h24, 0);

        // R2: readback masking and unknown addresses
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R2 level reg keeps 2 bits", 8'h30, 32'h3);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R2 enable reg keeps bit31", 8'h24, 32'h8000_0000);
        wr(8'h1C, 32'hA5A5_5A5A);
        rd_chk("R2 table reg 0x1C full", 8'h1C, 32'hA5A5_5A5A);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R2 unknown addr reads 0", 8'h08, 0);
        rd_chk("R2 unknown write left 0x1C", 8'h1C, 32'hA5A5_5A5A);
        rd_chk("R2 unknown write left 0x18", 8'h18, 0);
        rd_chk("R2 unknown write left 0x30", 8'h30, 32'h3);
        // enable write with bit31 clear disables (R2, R6)
        wr(8'h24, 32'h7FFF_FFFF);
        rd_chk("R2 enable cleared", 8'h24, 0);
        // R6: static fields with neighbouring bits set
        wr(8'h00, 32'hFF3F_FFFF);
        wr(8'h04, 32'h8FFF_FFFF);
        #1;
        chk("R6 static parent ignores neighbours", 32'(act_parent), 0);
        chk("R6 static div ignores neighbours", 32'(act_div), 0);
        wr(8'h00, 32'h0080_0000);
        wr(8'h04, 32'h3000_0000);
        #1;
        chk("R6 static parent", 32'(act_parent), 2);
        chk("R6 static div", 32'(act_div), 3);

        // R4: bits outside the fields of a half are ignored (level 3 = 0x1C low half)
        wr(8'h1C, 32'h0000_11FF & ~32'h0000_0600 | 32'h0000_4200);
        wr(8'h30, 32'h3);
        wr(8'h24, 32'h8000_0000);
        #1;
        chk("R4 field div", 32'(act_div), 2);
        chk("R4 field parent", 32'(act_parent), 1);
        chk("R4 field flag", 32'(act_flag), 0);

        // R10: a level write shows from the edge that samples it
        wr(8'h18, {half(3'd6, 1'b1, 2'd2), half(3'd1, 1'b0, 2'd0)});
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h0;
        #1;
        chk("R10 before edge keeps level 3", 32'(act_div), 2);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R10 after edge uses level 0", 32'(act_div), 6);

        // Vector walk: R3 mapping, R5 selection, R6 static, R7/R8/R9 search
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            wr(8'h18, {half(t.ldiv[0], t.lflag[0], t.lpar[0]), half(t.ldiv[1], t.lflag[1], t.lpar[1])});
            wr(8'h1C, {half(t.ldiv[2], t.lflag[2], t.lpar[2]), half(t.ldiv[3], t.lflag[3], t.lpar[3])});
            wr(8'h00, 32'(t.spar) << 22);
            wr(8'h04, 32'(t.sdiv) << 28);
            wr(8'h30, 32'(t.lvl));
            wr(8'h24, 32'(t.en) << 31);
            req_div = t.req;
            #1;
            if (t.en) begin
                chk($sformatf("R3 R5 vec%0d parent", v), 32'(act_parent), 32'(t.e_par));
                chk($sformatf("R3 R5 vec%0d div", v), 32'(act_div), 32'(t.e_div));
                chk($sformatf("R4 R5 vec%0d flag", v), 32'(act_flag), 32'(t.e_flag));
                if (t.e_err) chk($sformatf("R8 vec%0d err", v), 32'(req_err), 1);
                else         chk($sformatf("R7 vec%0d err", v), 32'(req_err), 0);
                chk($sformatf("R7 R8 vec%0d level", v), 32'(req_level), 32'(t.e_hit));
            end else begin
                chk($sformatf("R6 vec%0d parent", v), 32'(act_parent), 32'(t.e_par));
                chk($sformatf("R6 vec%0d div", v), 32'(act_div), 32'(t.e_div));
                chk($sformatf("R6 vec%0d flag", v), 32'(act_flag), 0);
                chk($sformatf("R9 vec%0d err", v), 32'(req_err), 1);
                chk($sformatf("R9 vec%0d level", v), 32'(req_level), 0);
            end
        end

        // R1: reset from a loaded state returns to the static path
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req_div = 3'd7;
        #1;
        chk("R1 reset clears div", 32'(act_div), 0);
        chk("R1 reset clears parent", 32'(act_parent), 0);
        chk("R1 reset raises err", 32'(req_err), 1);
        rd_chk("R1 reset clears 0x18", 8'h18, 0);

        finish_run();
    end

endmodule